// File: doc/BRIEF.md
# PLL Frequency-Ramp Configuration Sequencer

This block takes a PLL reprogramming request and carries out the whole safe update in hardware, so software does not have to order the steps itself. A single-cycle start pulse supplies four values: the reference frequency in kHz, a predivider, a multiplication factor and a final output divider. The sequencer first checks that the request is legal. It then turns frequency modulation off and clears the loss-of-lock reset enable. Next it programs the loop so that the output settles one divider step below the target. Once the lock status input rises, it steps the output divider down to its final value and turns the loss-of-lock interrupt back on.

Every step is one write to a synthesizer control register. A write is a one-cycle strobe carrying an address and a data word, and the next step waits for a write acknowledge. The sequencer keeps an image of the last word it wrote. Fields that a step does not change are therefore carried forward from that image.

Landing below the target first limits the supply current surge. The lock wait has a programmable timeout, so a loop that never locks cannot hang the block.

Top module: `pll_ramp_seq`

Control word layout (20 bits with default parameters):

| Bits | Field |
|------|-------|
| [1:0] | modulation depth |
| [2] | loss-of-lock reset enable |
| [3] | loss-of-lock interrupt enable |
| [7:4] | output divider |
| [11:8] | predivider |
| [19:12] | multiplication factor |

## Requirements
- R1: Every write issued carries modulation depth bits [1:0] = 00.
- R2: The first write is the stored image with depth cleared. The second write also clears the loss-of-lock reset enable, bit [2]. No write that changes the predivider or the multiplication factor is issued until an image with bit [2] = 0 and depth 00 has been acknowledged.
- R3: The third write is one word. It holds interrupt enable bit [3] = 0, bit [2] = 0 and depth 00, with the requested multiplication factor in [19:12], the requested predivider in [11:8] and the requested divider plus one in [7:4].
- R4: After the third write is acknowledged, no write is issued until the lock input is high. The fourth write then differs from the third only in [7:4], which now holds the requested final divider.
- R5: The fifth write equals the fourth with bit [3] = 1. After its acknowledge, done pulses high for exactly one cycle and busy falls.
- R6: A request whose final divider is below 2, or equal to the all-ones value (which cannot take the plus one), is rejected. Error pulses for one cycle and no write is issued.
- R7: A request is accepted only if the predivider is nonzero and predivider*4000 <= reference kHz <= predivider*20000. Otherwise error pulses for one cycle and no write is issued.
- R8: If lock does not rise within the requested number of cycles of lock wait, error pulses for one cycle and busy falls. No further write follows, so the interrupt stays disabled.
- R9: Each write strobe lasts exactly one cycle, always carries address CTRL_ADDR, and the next strobe comes only after wr_ack has been seen.
- R10: A start pulse that arrives while busy is high has no effect on the writes or on done.
- R11: Out of reset, busy, done, error and wr_stb are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled only while idle |
| ref_khz | input | REF_W | Reference frequency in kHz |
| prediv | input | PD_W | Requested predivider |
| mfd | input | MF_W | Requested multiplication factor |
| rfd | input | RD_W | Requested final output divider |
| timeout_cycles | input | TO_W | Lock wait limit in cycles |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 20 | Write data word (width derived from the field parameters) |
| wr_ack | input | 1 | Write acknowledge |
| lock | input | 1 | PLL lock status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| error | output | 1 | One-cycle pulse on reject or timeout |

## Verification
Some rules are checked by the assertions on every cycle:
- every strobe has modulation off and lasts one cycle;
- a change to the multiplier or predivider is never written while the stored image still has the reset enable set;
- the interrupt is off throughout the lock wait;
- done and error are single-cycle pulses that never coincide, and done arrives with the interrupt enabled.

Other behaviour only the bench scenarios can show:
- the exact five-word contents against an independent image model;
- the range boundaries at 4 and 20 MHz and the divider limits;
- the gap between the third and fourth writes matching the lock delay;
- the timeout leaving three writes behind;
- a start that arrives while busy being dropped.

// File: rtl/pll_ramp_pkg.sv
package pll_ramp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_ISSUE,
    S_WACK,
    S_LOCK
  } seq_state_t;

  localparam int unsigned STEP_W = 3;
  localparam logic [STEP_W-1:0] STEP_RELOCK = 3'd2;
  localparam logic [STEP_W-1:0] STEP_FINAL  = 3'd3;
  localparam logic [STEP_W-1:0] STEP_LAST   = 3'd4;

endpackage

// File: rtl/pll_ramp_check.sv
module pll_ramp_check #(
  parameter int unsigned REF_W  = 16,
  parameter int unsigned PD_W   = 4,
  parameter int unsigned RD_W   = 4,
  parameter int unsigned LO_KHZ = 4000,
  parameter int unsigned HI_KHZ = 20000
) (
  input  logic [REF_W-1:0] ref_khz,
  input  logic [PD_W-1:0]  prediv,
  input  logic [RD_W-1:0]  rfd,
  output logic             ok
);
  localparam int unsigned KHZ_W = $clog2(HI_KHZ + 1);
  localparam int unsigned MUL_W = PD_W + KHZ_W;
  localparam int unsigned CMP_W = ((MUL_W > REF_W) ? MUL_W : REF_W) + 1;

  logic [CMP_W-1:0] lo_lim, hi_lim, ref_ext;
  logic             pd_ok, band_ok, rfd_ok;

  always_comb begin
    lo_lim  = CMP_W'(prediv) * CMP_W'(LO_KHZ);
    hi_lim  = CMP_W'(prediv) * CMP_W'(HI_KHZ);
    ref_ext = CMP_W'(ref_khz);
    pd_ok   = (prediv != '0);
    band_ok = (ref_ext >= lo_lim) && (ref_ext <= hi_lim);
    rfd_ok  = (rfd >= RD_W'(2)) && (rfd != '1);
    ok      = pd_ok && band_ok && rfd_ok;
  end
endmodule

// File: rtl/pll_ramp_timer.sv
module pll_ramp_timer #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + TO_W'(1);
    end
  end

  assign expired = run && (cnt >= limit);

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0)); // R8
endmodule

// File: rtl/pll_ramp_word.sv
module pll_ramp_word
  import pll_ramp_pkg::*;
#(
  parameter int unsigned PD_W = 4,
  parameter int unsigned MF_W = 8,
  parameter int unsigned RD_W = 4,
  localparam int unsigned RFD_LSB = 4,
  localparam int unsigned PD_LSB  = RFD_LSB + RD_W,
  localparam int unsigned MF_LSB  = PD_LSB + PD_W,
  localparam int unsigned DATA_W  = MF_LSB + MF_W
) (
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] image,
  input  logic [PD_W-1:0]   req_prediv,
  input  logic [MF_W-1:0]   req_mfd,
  input  logic [RD_W-1:0]   req_rfd,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned LRE_BIT = 2;
  localparam int unsigned IRQ_BIT = 3;

  always_comb begin
    word = image;
    case (step)
      3'd0: word[1:0] = 2'b00;
      3'd1: begin
        word[1:0]     = 2'b00;
        word[LRE_BIT] = 1'b0;
      end
      default: begin
        word = '0;
        word[MF_LSB +: MF_W] = req_mfd;
        word[PD_LSB +: PD_W] = req_prediv;
        word[RFD_LSB +: RD_W] = (step == STEP_RELOCK) ? (req_rfd + RD_W'(1)) : req_rfd;
        word[IRQ_BIT] = (step == STEP_LAST);
      end
    endcase
  end
endmodule

// File: rtl/pll_ramp_seq.sv
module pll_ramp_seq
  import pll_ramp_pkg::*;
#(
  parameter int unsigned REF_W  = 16,
  parameter int unsigned PD_W   = 4,
  parameter int unsigned MF_W   = 8,
  parameter int unsigned RD_W   = 4,
  parameter int unsigned TO_W   = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LO_KHZ = 4000,
  parameter int unsigned HI_KHZ = 20000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [31:0] RESET_WORD = 32'h0000_817D,
  localparam int unsigned DATA_W = 4 + RD_W + PD_W + MF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_khz,
  input  logic [PD_W-1:0]   prediv,
  input  logic [MF_W-1:0]   mfd,
  input  logic [RD_W-1:0]   rfd,
  input  logic [TO_W-1:0]   timeout_cycles,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  input  logic              lock,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int unsigned LRE_BIT = 2;
  localparam int unsigned IRQ_BIT = 3;
  localparam int unsigned RFD_LSB = 4;
  localparam int unsigned PD_LSB  = RFD_LSB + RD_W;
  localparam int unsigned MF_LSB  = PD_LSB + PD_W;

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] image;
  logic [DATA_W-1:0] next_word;
  logic [REF_W-1:0]  lat_ref;
  logic [PD_W-1:0]   lat_pd;
  logic [MF_W-1:0]   lat_mf;
  logic [RD_W-1:0]   lat_rd;
  logic [TO_W-1:0]   lat_to;
  logic              chk_ok;
  logic              lock_expired;

  pll_ramp_check #(
    .REF_W(REF_W), .PD_W(PD_W), .RD_W(RD_W), .LO_KHZ(LO_KHZ), .HI_KHZ(HI_KHZ)
  ) u_check (
    .ref_khz(lat_ref), .prediv(lat_pd), .rfd(lat_rd), .ok(chk_ok)
  );

  pll_ramp_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst(rst), .run(state == S_LOCK), .limit(lat_to), .expired(lock_expired)
  );

  pll_ramp_word #(.PD_W(PD_W), .MF_W(MF_W), .RD_W(RD_W)) u_word (
    .step(step), .image(image), .req_prediv(lat_pd), .req_mfd(lat_mf),
    .req_rfd(lat_rd), .word(next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      step    <= '0;
      image   <= RESET_WORD[DATA_W-1:0];
      lat_ref <= '0;
      lat_pd  <= '0;
      lat_mf  <= '0;
      lat_rd  <= '0;
      lat_to  <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            lat_ref <= ref_khz;
            lat_pd  <= prediv;
            lat_mf  <= mfd;
            lat_rd  <= rfd;
            lat_to  <= timeout_cycles;
            busy    <= 1'b1;
            state   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (chk_ok) begin
            step  <= '0;
            state <= S_ISSUE;
          end else begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        S_ISSUE: begin
          wr_stb  <= 1'b1;
          wr_addr <= CTRL_ADDR;
          wr_data <= next_word;
          state   <= S_WACK;
        end
        S_WACK: begin
          if (wr_ack) begin
            image <= wr_data;
            if (step == STEP_LAST) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              step  <= step + STEP_W'(1);
              state <= (step == STEP_RELOCK) ? S_LOCK : S_ISSUE;
            end
          end
        end
        S_LOCK: begin
          if (lock) begin
            state <= S_ISSUE;
          end else if (lock_expired) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DEPTH_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_data[1:0] == 2'b00)); // R1

  AST_MULT_AFTER_LRE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ((wr_data[MF_LSB +: MF_W] != image[MF_LSB +: MF_W]) ||
                (wr_data[PD_LSB +: PD_W] != image[PD_LSB +: PD_W])))
    |-> (!image[LRE_BIT] && (image[1:0] == 2'b00))); // R2

  AST_LOCK_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOCK) |-> !image[IRQ_BIT]); // R3

  AST_FINAL_RFD_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && (step == STEP_FINAL)) |->
    (wr_data[RFD_LSB +: RD_W] + RD_W'(1) == image[RFD_LSB +: RD_W])); // R4

  AST_DONE_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
    done |-> (image[IRQ_BIT] && (image[RFD_LSB +: RD_W] >= RD_W'(2)))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && !chk_ok) |=> (error && !wr_stb && !busy)); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    error |-> (!busy && !done)); // R8

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R9

  AST_ACK_GATE: assert property (@(posedge clk) disable iff (rst)
    (state == S_WACK && !wr_ack) |=> (state == S_WACK)); // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != S_IDLE) |=> $stable(lat_mf)); // R10
endmodule

// File: tb/pll_ramp_seq_test.sv
module pll_ramp_seq_test;
  localparam logic [7:0] CTRL = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] ref_khz = '0;
  logic [3:0]  prediv = '0;
  logic [7:0]  mfd = '0;
  logic [3:0]  rfd = '0;
  logic [15:0] timeout_cycles = '0;
  logic        wr_stb;
  logic [7:0]  wr_addr;
  logic [19:0] wr_data;
  logic        wr_ack = 1'b0;
  logic        lock = 1'b1;
  logic        busy, done, error;

  always #4 clk = ~clk;

  pll_ramp_seq uut (
    .clk(clk), .rst(rst), .start(start), .ref_khz(ref_khz), .prediv(prediv),
    .mfd(mfd), .rfd(rfd), .timeout_cycles(timeout_cycles), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .lock(lock),
    .busy(busy), .done(done), .error(error)
  );

  typedef struct packed {
    logic [15:0] rk;
    logic [3:0]  pd;
    logic [7:0]  mf;
    logic [3:0]  rf;
    logic        ok;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd8000,  4'd1,  8'h20, 4'd3,  1'b1},
    '{16'd40000, 4'd2,  8'h30, 4'd2,  1'b1},
    '{16'd40000, 4'd10, 8'h41, 4'd4,  1'b1},
    '{16'd40000, 4'd11, 8'h41, 4'd4,  1'b0},
    '{16'd50000, 4'd2,  8'h22, 4'd3,  1'b0},
    '{16'd8000,  4'd1,  8'h20, 4'd1,  1'b0},
    '{16'd8000,  4'd1,  8'h20, 4'd15, 1'b0},
    '{16'd8000,  4'd0,  8'h20, 4'd3,  1'b0},
    '{16'd20000, 4'd4,  8'h55, 4'd14, 1'b1}
  };

  int n_checks = 0;
  int n_fail = 0;
  int nw = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;
  int lock_left = 0;
  int lock_delay = 20;
  bit never_lock = 1'b0;
  bit ack_pending = 1'b0;
  bit addr_bad = 1'b0;
  logic [19:0] wlog [8];
  logic        wlk  [8];
  int          wcyc [8];
  logic [19:0] img = 20'h0817D;
  logic [19:0] expw [5];

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mkword(input logic [7:0] mf, input logic [3:0] pd,
                                         input logic [3:0] rf, input logic irq);
    return {mf, pd, rf, irq, 1'b0, 2'b00};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (ack_pending) begin wr_ack = 1'b1; ack_pending = 1'b0; end
      else wr_ack = 1'b0;
      if (wr_stb) begin
        if (nw < 8) begin
          wlog[nw] = wr_data; wlk[nw] = lock; wcyc[nw] = cyc;
        end
        if (wr_addr != CTRL) addr_bad = 1'b1;
        nw++;
        ack_pending = 1'b1;
        if (nw == 3) begin
          lock = 1'b0;
          lock_left = never_lock ? -1 : lock_delay;
        end
      end else if (lock_left > 0) begin
        lock_left--;
        if (lock_left == 0) lock = 1'b1;
      end
      if (done) done_cnt++;
      if (error) err_cnt++;
      cyc++;
    end
  end

  task automatic run(input vec_t v, input logic [15:0] to, input bit nolock, input bit again);
    nw = 0; done_cnt = 0; err_cnt = 0; never_lock = nolock; addr_bad = 1'b0;
    @(negedge clk);
    ref_khz = v.rk; prediv = v.pd; mfd = v.mf; rfd = v.rf; timeout_cycles = to;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (again) begin
      repeat (4) @(negedge clk);
      mfd = ~v.mf; rfd = 4'd6; prediv = 4'd2; ref_khz = 16'd16000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_ok(input vec_t v, input string tag);
    expw[0] = {img[19:2], 2'b00};
    expw[1] = {img[19:3], 1'b0, 2'b00};
    expw[2] = mkword(v.mf, v.pd, v.rf + 4'd1, 1'b0);
    expw[3] = mkword(v.mf, v.pd, v.rf, 1'b0);
    expw[4] = mkword(v.mf, v.pd, v.rf, 1'b1);
    check(nw == 5, {tag, " R5 write count"}, nw, 5);
    for (int i = 0; i < 5; i++)
      check(wlog[i] == expw[i], $sformatf("%s R1 R2 R3 R4 R5 word %0d", tag, i), wlog[i], expw[i]);
    check(wlk[3] == 1'b1, {tag, " R4 lock before final divider"}, wlk[3], 1);
    check(wcyc[3] - wcyc[2] > lock_delay, {tag, " R4 lock wait gap"}, wcyc[3] - wcyc[2], lock_delay);
    check(done_cnt == 1 && err_cnt == 0, {tag, " R5 done pulse"}, done_cnt, 1);
    check(!addr_bad, {tag, " R9 address"}, addr_bad, 0);
    img = expw[4];
  endtask

  initial begin
    vec_t tv;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !wr_stb, "R11 reset outputs", {busy, done, error, wr_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !wr_stb, "R11 idle after reset", {busy, wr_stb}, 0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 16'd200, 1'b0, 1'b0);
      if (VECS[i].ok) expect_ok(VECS[i], $sformatf("vec%0d R7", i));
      else begin
        check(nw == 0, $sformatf("vec%0d R6 R7 no writes", i), nw, 0);
        check(err_cnt == 1 && done_cnt == 0, $sformatf("vec%0d R6 R7 error pulse", i), err_cnt, 1);
      end
    end

    // R10: second start while busy is dropped
    tv = '{16'd12000, 4'd2, 8'h66, 4'd5, 1'b1};
    run(tv, 16'd200, 1'b0, 1'b1);
    expect_ok(tv, "R10 busy start");

    // R8: lock never arrives
    tv = '{16'd10000, 4'd1, 8'h77, 4'd3, 1'b1};
    run(tv, 16'd10, 1'b1, 1'b0);
    check(nw == 3, "R8 writes before timeout", nw, 3);
    check(err_cnt == 1 && done_cnt == 0, "R8 timeout error", err_cnt, 1);
    check(!busy, "R8 idle after timeout", busy, 0);
    check(wlog[2][3] == 1'b0, "R8 interrupt left off", wlog[2][3], 0);
    img = mkword(8'h77, 4'd1, 4'd4, 1'b0);
    lock = 1'b1; lock_left = 0;

    // recovery after timeout
    tv = '{16'd6000, 4'd1, 8'h12, 4'd2, 1'b1};
    run(tv, 16'd200, 1'b0, 1'b0);
    expect_ok(tv, "R2 after timeout");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule